// File: doc/BRIEF.md
# Low-Power Mode Unlock Sequencer

This block sits beside a pseudo-static memory array and watches the single read and write operations that reach it. A power-down mode is programmed by a fixed six-operation pattern aimed at the top address. First a read of the top address supplies a reference word. Two writes echo that word back. Two writes follow whose data does not matter. A final read selects the mode through its address. The mode is either deep sleep, which is also the reset default, or one of three partial-array retention sizes.

Along the way the block decides, for every write, whether that write reaches the array as an ordinary write. An echo write that breaks the pattern is still committed. Any write that lands on one of the two don't-care steps is withheld, including one that breaks the pattern. A sticky flag reports that the retained array contents may be lost, which happens when the mode moves between two different partial sizes.

Top module: `pwr_unlock_seq`

## Requirements
- R1: After reset, mode is 2'b11 (sleep), mode_load is 0 and loss is 0.
- R2: An operation is the cycle in which rd_stb or wr_stb goes from low to high. A strobe held high for several cycles counts once. For a read, rd_data is sampled in that same cycle.
- R3: The sequence is: a read of 0x3FFFFF, two writes to 0x3FFFFF carrying the word read, two writes to 0x3FFFFF, then a key read. A key has bit 21 set and bits 18..0 all ones. The key sets mode to its bits 20..19: 11 sleep (0x3FFFFF), 10 4M (0x37FFFF), 01 8M (0x2FFFFF), 00 16M (0x27FFFF). Mode updates at the clock edge that ends the key read.
- R4: mode_load is high for exactly the one cycle after every accepted key read, even when the mode value does not change.
- R5: At step 2 or 3, a write whose address is not 0x3FFFFF, or whose data differs from the reference word, abandons the sequence. That write is committed (wr_commit high), as are the matching echo writes.
- R6: At steps 4 and 5 the write data is ignored and wr_commit stays low, both for matching writes and for a write to another address. A write to another address also abandons the sequence.
- R7: An operation not preceded by at least one cycle of standby since the previous operation (or since reset) abandons the sequence and is handled as an ordinary operation.
- R8: A read at steps 2 to 5, or a write at step 6, abandons the sequence. Such a write is committed.
- R9: A key read whose address is not a valid key leaves mode unchanged and produces no mode_load.
- R10: loss becomes 1 when mode changes from one partial size to a different partial size. It stays 1 until reset.
- R11: Outside the withheld steps, wr_commit is high in the cycle of every write operation, and it is low in any cycle without a write operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 22 | Operation address |
| rd_stb | input | 1 | Read strobe, rising edge starts a read |
| wr_stb | input | 1 | Write strobe, rising edge starts a write |
| wr_data | input | DW | Write data |
| rd_data | input | DW | Data returned by the array for a read |
| standby | input | 1 | Device is in standby |
| mode | output | 2 | Selected power-down mode |
| mode_load | output | 1 | One-cycle pulse after an accepted key |
| wr_commit | output | 1 | Current write goes to the array normally |
| loss | output | 1 | Sticky flag: partial-to-partial change |

## Verification
Complete sequences are run with every valid key, in an order that separates a sleep-to-partial change, a repeat of the same partial size, and a partial-to-partial change, so the loss flag is exercised in each case. Broken sequences are applied at each step: a wrong address, wrong echo data, a missing standby gap, and the wrong operation type. These show which aborting writes are committed and which are withheld, and that the mode stays put. A strobe held over several cycles while rd_data changes separates edge-based operation counting and capture from level-based counting and capture. Invalid keys, and a clean sequence run after each abort, show that the block returns to idle correctly.

// File: rtl/pwr_unlock_seq.sv
module pwr_unlock_seq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [21:0]   addr,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rd_data,
  input  logic          standby,
  output logic [1:0]    mode,
  output logic          mode_load,
  output logic          wr_commit,
  output logic          loss
);
  localparam logic [21:0] TOP   = 22'h3FFFFF;
  localparam logic [1:0]  SLEEP = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_ECHO1, S_ECHO2, S_FILL1, S_FILL2, S_KEY} st_t;
  st_t st;

  logic          rd_q, wr_q, rested;
  logic [DW-1:0] ref_w;

  wire rd_op   = rd_stb & ~rd_q;
  wire wr_op   = wr_stb & ~wr_q;
  wire any_op  = rd_op | wr_op;
  wire at_top  = (addr == TOP);
  wire echo_ok = wr_op & at_top & (wr_data == ref_w);
  wire fill_ok = wr_op & at_top;
  wire in_fill = (st == S_FILL1) || (st == S_FILL2);
  wire key_ok  = rd_op & addr[21] & (&addr[18:0]);
  wire [1:0] new_mode = addr[20:19];
  wire part_swap = (mode != SLEEP) && (new_mode != SLEEP) && (new_mode != mode);

  assign wr_commit = wr_op & ~(rested & in_fill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      rested    <= 1'b0;
      ref_w     <= '0;
      mode      <= SLEEP;
      mode_load <= 1'b0;
      loss      <= 1'b0;
    end else begin
      rd_q      <= rd_stb;
      wr_q      <= wr_stb;
      mode_load <= 1'b0;
      rested    <= any_op ? 1'b0 : (rested | standby);
      if (any_op) begin
        st <= S_IDLE;
        if (rested) begin
          case (st)
            S_IDLE:  if (rd_op && at_top) begin
                       ref_w <= rd_data;
                       st    <= S_ECHO1;
                     end
            S_ECHO1: if (echo_ok) st <= S_ECHO2;
            S_ECHO2: if (echo_ok) st <= S_FILL1;
            S_FILL1: if (fill_ok) st <= S_FILL2;
            S_FILL2: if (fill_ok) st <= S_KEY;
            S_KEY:   if (key_ok) begin
                       mode      <= new_mode;
                       mode_load <= 1'b1;
                       if (part_swap) loss <= 1'b1;
                     end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwr_unlock_seq_chk.sv
module pwr_unlock_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       wr_commit,
  input logic [1:0] mode,
  input logic       mode_load,
  input logic       loss
);
  AST_MODE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> mode_load); // R3
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> !mode_load); // R4
  AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loss |=> loss); // R10
  AST_LOSS_PARTIAL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loss) |-> (mode != 2'b11 && $past(mode) != 2'b11 && mode != $past(mode))); // R10
  AST_COMMIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> wr_stb); // R11
endmodule

bind pwr_unlock_seq pwr_unlock_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_commit(wr_commit),
  .mode(mode), .mode_load(mode_load), .loss(loss)
);

// File: tb/pwr_unlock_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_unlock_seq_tb_top;
  localparam logic [21:0] TOP = 22'h3FFFFF;
  logic clk = 0, rst_n = 0;
  logic [21:0] addr = '0;
  logic rd_stb = 0, wr_stb = 0, standby = 0;
  logic [15:0] wr_data = '0, rd_data = '0;
  logic [1:0] mode;
  logic mode_load, wr_commit, loss;
  int total = 0, bad = 0, cyc = 0;
  logic c_commit, c_ld1, c_ld2;

  pwr_unlock_seq #(.DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .standby(standby),
    .mode(mode), .mode_load(mode_load), .wr_commit(wr_commit), .loss(loss));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; rd_stb = 0; wr_stb = 0; standby = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic op(input bit is_rd, input logic [21:0] a, input logic [15:0] d, input bit sb);
    @(negedge clk); standby = sb; rd_stb = 0; wr_stb = 0;
    @(negedge clk); standby = 0; addr = a;
    if (is_rd) begin rd_data = d; rd_stb = 1; end
    else begin wr_data = d; wr_stb = 1; end
    #1 c_commit = wr_commit;
    @(negedge clk); rd_stb = 0; wr_stb = 0; c_ld1 = mode_load;
    @(negedge clk); c_ld2 = mode_load;
  endtask

  task automatic full(input logic [21:0] key, input logic [15:0] w, input string req);
    op(1, TOP, w, 1);
    op(0, TOP, w, 1); check({req, " R5 echo1 commit"}, c_commit, 1);
    op(0, TOP, w, 1); check({req, " R5 echo2 commit"}, c_commit, 1);
    op(0, TOP, w ^ 16'h5a5a, 1); check({req, " R6 fill1 withheld"}, c_commit, 0);
    op(0, TOP, 16'h0, 1); check({req, " R6 fill2 withheld"}, c_commit, 0);
    op(1, key, 16'h0, 1);
    check({req, " R4 load pulse"}, c_ld1, 1);
    check({req, " R4 load one cycle"}, c_ld2, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 mode", mode, 2'b11);
    check("R1 load", mode_load, 0);
    check("R1 loss", loss, 0);
  endtask

  task automatic t_modes();
    do_reset();
    full(22'h27FFFF, 16'h1234, "R3 16M"); check("R3 mode 16M", mode, 2'b00); check("R10 no loss", loss, 0);
    full(22'h3FFFFF, 16'hABCD, "R3 sleep"); check("R3 mode sleep", mode, 2'b11); check("R10 no loss sleep", loss, 0);
    full(22'h37FFFF, 16'h0F0F, "R3 4M"); check("R3 mode 4M", mode, 2'b10); check("R10 no loss from sleep", loss, 0);
    full(22'h37FFFF, 16'h7777, "R4 same"); check("R4 same mode", mode, 2'b10); check("R10 no loss same", loss, 0);
    full(22'h2FFFFF, 16'h8001, "R3 8M"); check("R3 mode 8M", mode, 2'b01); check("R10 loss set", loss, 1);
    full(22'h3FFFFF, 16'h2222, "R10 sticky"); check("R3 back sleep", mode, 2'b11); check("R10 loss sticky", loss, 1);
    do_reset(); check("R10 loss cleared by reset", loss, 0);
  endtask

  task automatic t_held_strobe();
    do_reset();
    @(negedge clk); standby = 1;
    @(negedge clk); standby = 0; addr = TOP; rd_data = 16'hC0DE; rd_stb = 1;
    @(negedge clk); rd_data = 16'hBAD0;
    @(negedge clk); rd_data = 16'hBAD1;
    @(negedge clk); rd_stb = 0;
    op(0, TOP, 16'hC0DE, 1); check("R2 echo1 commit", c_commit, 1);
    op(0, TOP, 16'hC0DE, 1);
    op(0, TOP, 16'h1, 1); op(0, TOP, 16'h2, 1);
    op(1, 22'h2FFFFF, 16'h0, 1);
    check("R2 held strobe single op", mode, 2'b01);
    check("R2 load", c_ld1, 1);
  endtask

  task automatic t_plain();
    do_reset();
    op(0, 22'h001234, 16'h55AA, 1); check("R11 plain write commit", c_commit, 1);
    op(1, 22'h001234, 16'h55AA, 1); check("R11 read no commit", c_commit, 0);
    op(0, 22'h000010, 16'h1, 0); check("R11 write without standby commit", c_commit, 1);
  endtask

  task automatic t_abort_echo();
    do_reset();
    op(1, TOP, 16'h4444, 1);
    op(0, 22'h000100, 16'h4444, 1); check("R5 wrong addr commit", c_commit, 1);
    op(0, TOP, 16'h4444, 1); op(0, TOP, 16'h0, 1); op(0, TOP, 16'h0, 1);
    op(1, 22'h37FFFF, 16'h0, 1);
    check("R5 mode unchanged addr", mode, 2'b11); check("R5 no load addr", c_ld1, 0);
    op(1, TOP, 16'h4444, 1);
    op(0, TOP, 16'h4444, 1);
    op(0, TOP, 16'h4445, 1); check("R5 wrong data commit", c_commit, 1);
    op(0, TOP, 16'h0, 1); op(0, TOP, 16'h0, 1);
    op(1, 22'h37FFFF, 16'h0, 1);
    check("R5 mode unchanged data", mode, 2'b11);
    full(22'h37FFFF, 16'h9999, "R5 restart"); check("R5 restart mode", mode, 2'b10);
  endtask

  task automatic t_abort_fill();
    do_reset();
    op(1, TOP, 16'h3333, 1); op(0, TOP, 16'h3333, 1); op(0, TOP, 16'h3333, 1);
    op(0, 22'h000123, 16'hFFFF, 1); check("R6 abort write withheld", c_commit, 0);
    op(0, TOP, 16'h0, 1); check("R6 after abort plain commit", c_commit, 1);
    op(1, 22'h27FFFF, 16'h0, 1);
    check("R6 mode unchanged", mode, 2'b11); check("R6 no load", c_ld1, 0);
    full(22'h27FFFF, 16'h3333, "R6 restart"); check("R6 restart mode", mode, 2'b00);
  endtask

  task automatic t_standby();
    do_reset();
    op(1, TOP, 16'h6666, 1);
    op(0, TOP, 16'h6666, 0); check("R7 no standby echo commit", c_commit, 1);
    op(0, TOP, 16'h6666, 1); op(0, TOP, 16'h0, 1); op(0, TOP, 16'h0, 1);
    op(1, 22'h37FFFF, 16'h0, 1); check("R7 mode unchanged echo", mode, 2'b11);
    op(1, TOP, 16'h6666, 1); op(0, TOP, 16'h6666, 1); op(0, TOP, 16'h6666, 1);
    op(0, TOP, 16'h0, 0); check("R7 no standby fill commit", c_commit, 1);
    op(0, TOP, 16'h0, 1);
    op(1, 22'h37FFFF, 16'h0, 1); check("R7 mode unchanged fill", mode, 2'b11);
    check("R7 no load", c_ld1, 0);
  endtask

  task automatic t_wrong_type();
    do_reset();
    op(1, TOP, 16'h7070, 1); op(0, TOP, 16'h7070, 1); op(0, TOP, 16'h7070, 1);
    op(1, TOP, 16'h0, 1);
    op(0, TOP, 16'h0, 1); check("R8 read at fill aborts", c_commit, 1);
    op(1, 22'h2FFFFF, 16'h0, 1); check("R8 mode unchanged read", mode, 2'b11);
    op(1, TOP, 16'h7070, 1); op(0, TOP, 16'h7070, 1); op(0, TOP, 16'h7070, 1);
    op(0, TOP, 16'h0, 1); op(0, TOP, 16'h0, 1);
    op(0, 22'h2FFFFF, 16'h0, 1); check("R8 write at key commit", c_commit, 1);
    check("R8 mode unchanged write", mode, 2'b11); check("R8 no load", c_ld1, 0);
  endtask

  task automatic t_bad_key();
    do_reset();
    full(22'h2FFFFF, 16'h1111, "R9 setup");
    op(1, TOP, 16'h2, 1); op(0, TOP, 16'h2, 1); op(0, TOP, 16'h2, 1);
    op(0, TOP, 16'h0, 1); op(0, TOP, 16'h0, 1);
    op(1, 22'h1FFFFF, 16'h0, 1);
    check("R9 bit21 clear no load", c_ld1, 0); check("R9 mode kept", mode, 2'b01);
    op(1, TOP, 16'h2, 1); op(0, TOP, 16'h2, 1); op(0, TOP, 16'h2, 1);
    op(0, TOP, 16'h0, 1); op(0, TOP, 16'h0, 1);
    op(1, 22'h37FFFE, 16'h0, 1);
    check("R9 low bits no load", c_ld1, 0); check("R9 mode kept low bits", mode, 2'b01);
    check("R9 no loss", loss, 0);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_held_strobe();
    t_plain();
    t_abort_echo();
    t_abort_fill();
    t_standby();
    t_wrong_type();
    t_bad_key();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule